// File: doc/BRIEF.md
# Hot-Plug Controller Indirect Register Window

This block gives software two ways into a hot-plug controller's register file. The first is an 8-byte capability in configuration space. That capability holds a select byte, which names a controller dword, and a data dword, which mirrors the dword that was named. When a configuration write lands on the data dword, the block passes the whole data value on to the controller as a 4-byte write at byte address select×4. After any configuration write that touches the capability, the block reloads the mirror from the controller. The register file itself, and the command and interrupt logic behind it, sit outside this block. The block reaches them through one byte-addressed internal port, whose read data is combinational.

The second way in is a memory-mapped aperture. It takes little-endian accesses of 1 to 4 bytes. Its address space is sized for the largest slot count, rounded up to a power of two. The block checks each aperture access against the real register file size, which is 0x24 + 4×NSLOTS bytes. An access that starts past the end touches nothing and reads zero. An access that runs past the end is cut down to the bytes that exist.

While the capability's write-then-reload sequence holds the internal port, `cfg_busy` is high. In that time the block drops further configuration writes and does not acknowledge aperture requests.

Top module: `hp_cfg_window`

## Requirements
- R1: After reset the select byte and the data dword both read 0, `cfg_busy` is low and the internal port is idle.
- R2: Reads work as follows. Capability dword 0 (configuration dword index CAP_PTR/4) returns the select value in bits 23:16, with bits 31:24 and 15:0 always 0. Dword 1 returns the data mirror. Any other configuration dword returns 0.
- R3: Any configuration write with a nonzero byte enable to either capability dword updates the select byte when byte enable 2 of dword 0 is set. It then starts a reload: in the last sequence cycle the port reads 4 bytes at select×4 (rf_en=1, rf_we=0, rf_be=4'b1111), and at the end of that cycle the mirror takes the port data.
- R4: A write to capability dword 1 merges its enabled byte lanes into the mirror. In the next cycle the whole mirror goes out as a port write (rf_we=1, rf_be=4'b1111) at select×4. The reload of that same address follows in the cycle after that, so the reload returns the value just written.
- R5: If select×4 is at or past the register file size, the forwarded write is dropped with no port activity, and the reload puts 0 into the mirror.
- R6: A configuration write to any dword outside the capability changes no state, starts no port activity and leaves `cfg_busy` low.
- R7: `cfg_busy` is high for each sequence cycle: one cycle for a reload alone, two for a write plus reload. Configuration writes that arrive while it is high are ignored.
- R8: `ap_ack` equals `ap_req` while `cfg_busy` is low and is 0 while it is high. During an acknowledged in-range access the port carries the aperture address, direction and write data.
- R9: The aperture size code n (0 to 3) means n+1 bytes. Byte lane i maps to address ap_addr+i. rf_be sets the lowest lanes, and read lanes that were not enabled return 0.
- R10: An aperture access with ap_addr at or past the register file size is acknowledged. It produces no port activity, and a read returns 0.
- R11: An aperture access that runs past the register file end enables only the lanes below the end, and the other read lanes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration dword index, used for both read and write |
| cfg_be | input | 4 | Configuration write byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| cfg_busy | output | 1 | Capability sequence owns the internal port |
| ap_req | input | 1 | Aperture access request, held until acknowledged |
| ap_we | input | 1 | Aperture write when high |
| ap_addr | input | AP_AW | Aperture byte address |
| ap_size | input | 2 | Access length minus one, in bytes |
| ap_wdata | input | 32 | Aperture write data, lane 0 at ap_addr |
| ap_ack | output | 1 | Aperture access taken this cycle |
| ap_rdata | output | 32 | Aperture read data, valid with ap_ack |
| rf_en | output | 1 | Internal port access enable |
| rf_we | output | 1 | Internal port write when high |
| rf_addr | output | AP_AW | Internal port byte address |
| rf_be | output | 4 | Internal port byte-lane enables |
| rf_wdata | output | 32 | Internal port write data |
| rf_rdata | input | 32 | Internal port combinational read data |

## Verification
On every cycle the assertions check these rules:
- no aperture acknowledge while a sequence runs;
- every forwarded write is followed at once by a reload of the same address;
- a sequence never lasts more than two cycles;
- port accesses never reach past the register file end;
- out-of-range aperture accesses stay off the port;
- writes outside the capability never start a sequence.

Some results can only be shown by the bench's scenarios:
- that the mirror ends up holding the value just written;
- the byte-lane merging;
- the zero reload for out-of-range selects;
- the little-endian lane contents and the truncation at the end of the file;
- that a configuration write dropped during a sequence leaves the select byte unchanged.

// File: rtl/hp_cfg_window.sv
module hp_cfg_window #(
  parameter int NSLOTS  = 31,
  parameter int CAP_PTR = 'h48,
  parameter int CFG_AW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_busy,
  input  logic              ap_req,
  input  logic              ap_we,
  input  logic [pow2up(36 + 4*31) > 1 ? $clog2(pow2up(36 + 4*31))-1 : 0:0] ap_addr,
  input  logic [1:0]        ap_size,
  input  logic [31:0]       ap_wdata,
  output logic              ap_ack,
  output logic [31:0]       ap_rdata,
  output logic              rf_en,
  output logic              rf_we,
  output logic [pow2up(36 + 4*31) > 1 ? $clog2(pow2up(36 + 4*31))-1 : 0:0] rf_addr,
  output logic [3:0]        rf_be,
  output logic [31:0]       rf_wdata,
  input  logic [31:0]       rf_rdata
);
  function automatic int pow2up(int v);
    int p = 1;
    while (p < v) p = p * 2;
    return p;
  endfunction

  localparam int RF_BYTES  = 36 + 4 * NSLOTS;
  localparam int RF_DWORDS = RF_BYTES / 4;
  localparam int AP_BYTES  = pow2up(36 + 4 * 31);
  localparam int AP_AW     = $clog2(AP_BYTES);
  localparam int CAP_DW    = CAP_PTR / 4;

  logic [7:0]  sel_q;
  logic [31:0] data_q;
  logic        fwd_pend, ref_pend;

  logic hit0, hit1, take, sel_in_rng;
  logic [AP_AW-1:0] win_addr;

  assign hit0       = cfg_addr == CFG_AW'(CAP_DW);
  assign hit1       = cfg_addr == CFG_AW'(CAP_DW + 1);
  assign cfg_busy   = fwd_pend | ref_pend;
  assign take       = cfg_wr & ~cfg_busy & (hit0 | hit1) & (|cfg_be);
  assign sel_in_rng = {1'b0, sel_q} < 9'(RF_DWORDS);
  assign win_addr   = AP_AW'({sel_q, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      data_q   <= '0;
      fwd_pend <= 1'b0;
      ref_pend <= 1'b0;
    end else if (take) begin
      if (hit0 && cfg_be[2]) sel_q <= cfg_wdata[23:16];
      if (hit1)
        for (int b = 0; b < 4; b++)
          if (cfg_be[b]) data_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
      fwd_pend <= hit1;
      ref_pend <= 1'b1;
    end else if (fwd_pend) begin
      fwd_pend <= 1'b0;
    end else if (ref_pend) begin
      data_q   <= sel_in_rng ? rf_rdata : 32'h0;
      ref_pend <= 1'b0;
    end
  end

  assign cfg_rdata = hit0 ? {8'h00, sel_q, 16'h0000} :
                     hit1 ? data_q : 32'h0;

  logic             ap_in;
  logic [AP_AW:0]   room;
  logic [2:0]       nbytes, eff;
  logic [3:0]       ap_be;

  assign ap_in  = {1'b0, ap_addr} < (AP_AW+1)'(RF_BYTES);
  assign room   = (AP_AW+1)'(RF_BYTES) - {1'b0, ap_addr};
  assign nbytes = {1'b0, ap_size} + 3'd1;
  assign eff    = !ap_in ? 3'd0 :
                  (room < (AP_AW+1)'(nbytes)) ? room[2:0] : nbytes;

  always_comb begin
    case (eff)
      3'd1:    ap_be = 4'b0001;
      3'd2:    ap_be = 4'b0011;
      3'd3:    ap_be = 4'b0111;
      3'd4:    ap_be = 4'b1111;
      default: ap_be = 4'b0000;
    endcase
  end

  assign ap_ack = ap_req & ~cfg_busy;

  always_comb begin
    rf_en    = 1'b0;
    rf_we    = 1'b0;
    rf_addr  = '0;
    rf_be    = 4'b0000;
    rf_wdata = 32'h0;
    if (fwd_pend) begin
      rf_en    = sel_in_rng;
      rf_we    = 1'b1;
      rf_addr  = win_addr;
      rf_be    = 4'b1111;
      rf_wdata = data_q;
    end else if (ref_pend) begin
      rf_en   = sel_in_rng;
      rf_addr = win_addr;
      rf_be   = 4'b1111;
    end else if (ap_ack && ap_in) begin
      rf_en    = 1'b1;
      rf_we    = ap_we;
      rf_addr  = ap_addr;
      rf_be    = ap_be;
      rf_wdata = ap_wdata;
    end
  end

  assign ap_rdata = (ap_ack && ap_in && !ap_we) ?
                    (rf_rdata & {{8{ap_be[3]}}, {8{ap_be[2]}}, {8{ap_be[1]}}, {8{ap_be[0]}}}) :
                    32'h0;

  assert_no_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |-> !ap_ack);

  assert_reload_follows_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_en && rf_we && cfg_busy) |=> (rf_en && !rf_we && rf_addr == $past(rf_addr)));

  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && $past(cfg_busy)) |=> !cfg_busy);

  assert_port_in_file_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> (int'(rf_addr) + $countones(rf_be) <= RF_BYTES));

  assert_oob_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_ack && int'(ap_addr) >= RF_BYTES) |-> !rf_en);

  assert_outside_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_busy && cfg_wr && !hit0 && !hit1) |=> !cfg_busy);

  assert_lanes_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> (rf_be == 4'b0001 || rf_be == 4'b0011 || rf_be == 4'b0111 || rf_be == 4'b1111));
endmodule

// File: tb/hp_cfg_window_tb.sv
module hp_cfg_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RFB = 160;
  localparam logic [5:0] D0 = 6'd18;
  localparam logic [5:0] D1 = 6'd19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0; logic [5:0] cfg_addr = '0; logic [3:0] cfg_be = '0; logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata; logic cfg_busy;
  logic ap_req = 1'b0, ap_we = 1'b0; logic [7:0] ap_addr = '0; logic [1:0] ap_size = '0; logic [31:0] ap_wdata = '0;
  logic ap_ack; logic [31:0] ap_rdata;
  logic rf_en, rf_we; logic [7:0] rf_addr; logic [3:0] rf_be; logic [31:0] rf_wdata, rf_rdata;

  int total = 0, bad = 0;
  logic [7:0] mem [RFB];
  logic [7:0] ref_mem [RFB];
  logic [7:0] sel_m = '0;
  logic [31:0] data_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_cfg_window dut_i (.*);

  always_comb begin
    rf_rdata = '0;
    for (int i = 0; i < 4; i++)
      if (int'(rf_addr) + i < RFB) rf_rdata[8*i +: 8] = mem[int'(rf_addr) + i];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RFB; i++) mem[i] <= 8'(i * 37 + 5);
    end else if (rf_en && rf_we) begin
      for (int i = 0; i < 4; i++)
        if (rf_be[i] && int'(rf_addr) + i < RFB) mem[int'(rf_addr) + i] <= rf_wdata[8*i +: 8];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(int a);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) if (a + i < RFB) w[8*i +: 8] = ref_mem[a + i];
    return w;
  endfunction

  function automatic int eff_bytes(int a, int sz);
    int n = sz + 1;
    if (a >= RFB) return 0;
    return (RFB - a < n) ? RFB - a : n;
  endfunction

  task automatic cfg_read_chk(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic cfg_write(logic [5:0] a, logic [3:0] be, logic [31:0] wd);
    logic h0 = (a == D0), h1 = (a == D1);
    logic inr;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!(h0 || h1) || be == 4'b0) begin
      chk("R6 busy", 32'(cfg_busy), 32'd0);
      chk("R6 port", 32'(rf_en), 32'd0);
      cfg_read_chk("R6 sel", D0, {8'h0, sel_m, 16'h0});
      cfg_read_chk("R6 data", D1, data_m);
      return;
    end
    if (h0 && be[2]) sel_m = wd[23:16];
    if (h1) for (int b = 0; b < 4; b++) if (be[b]) data_m[8*b +: 8] = wd[8*b +: 8];
    inr = int'(sel_m) * 4 < RFB;
    if (h1) begin
      chk("R7 busy fwd", 32'(cfg_busy), 32'd1);
      chk("R5 fwd en", 32'(rf_en), 32'(inr));
      if (inr) begin
        chk("R4 fwd we", 32'(rf_we), 32'd1);
        chk("R4 fwd addr", 32'(rf_addr), int'(sel_m) * 4);
        chk("R4 fwd be", 32'(rf_be), 32'hf);
        chk("R4 fwd data", rf_wdata, data_m);
        for (int i = 0; i < 4; i++) ref_mem[int'(sel_m) * 4 + i] = data_m[8*i +: 8];
      end
      @(negedge clk);
    end
    chk("R7 busy reload", 32'(cfg_busy), 32'd1);
    chk("R3 reload en", 32'(rf_en), 32'(inr));
    if (inr) begin
      chk("R3 reload we", 32'(rf_we), 32'd0);
      chk("R3 reload addr", 32'(rf_addr), int'(sel_m) * 4);
    end
    data_m = inr ? ref_word(int'(sel_m) * 4) : 32'h0;
    @(negedge clk);
    chk("R7 busy end", 32'(cfg_busy), 32'd0);
    cfg_read_chk(inr ? "R3 mirror" : "R5 mirror zero", D1, data_m);
    cfg_read_chk("R2 dword0", D0, {8'h0, sel_m, 16'h0});
  endtask

  task automatic ap_access(logic we, int a, int sz, logic [31:0] wd);
    int n = eff_bytes(a, sz);
    logic [31:0] exp_rd = '0;
    for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = ref_mem[a + i];
    @(negedge clk);
    ap_req = 1'b1; ap_we = we; ap_addr = 8'(a); ap_size = 2'(sz); ap_wdata = wd;
    #1;
    chk("R8 ack", 32'(ap_ack), 32'd1);
    if (n == 0) begin
      chk("R10 no port", 32'(rf_en), 32'd0);
      if (!we) chk("R10 read zero", ap_rdata, 32'h0);
    end else begin
      chk("R8 port addr", 32'(rf_addr), 32'(a));
      chk("R8 port we", 32'(rf_we), 32'(we));
      chk(n < sz + 1 ? "R11 trunc be" : "R9 be", 32'(rf_be), 32'((1 << n) - 1));
      if (!we) chk(n < sz + 1 ? "R11 trunc data" : "R9 lanes", ap_rdata, exp_rd);
      else chk("R8 port wdata", rf_wdata, wd);
    end
    @(negedge clk);
    ap_req = 1'b0;
    if (we) for (int i = 0; i < n; i++) ref_mem[a + i] = wd[8*i +: 8];
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < RFB; i++) ref_mem[i] = 8'(i * 37 + 5);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 busy", 32'(cfg_busy), 32'd0);
    chk("R1 port idle", 32'(rf_en), 32'd0);
    cfg_read_chk("R1 sel", D0, 32'h0);
    cfg_read_chk("R1 data", D1, 32'h0);
    cfg_read_chk("R2 other dword", 6'd20, 32'h0);

    cfg_write(D0, 4'b0100, 32'h0005_0000);
    cfg_write(D1, 4'b1111, 32'hCAFE_F00D);
    cfg_write(D1, 4'b0101, 32'h1122_3344);
    cfg_write(D0, 4'b1011, 32'hFFFF_FFFF);
    cfg_write(6'd17, 4'b1111, 32'h0009_0000);
    cfg_write(D0, 4'b0000, 32'h0009_0000);
    cfg_write(D0, 4'b0100, 32'h0027_0000);
    cfg_write(D1, 4'b1111, 32'hA5A5_0001);
    cfg_write(D0, 4'b0100, 32'h0028_0000);
    cfg_write(D1, 4'b1111, 32'hDEAD_BEEF);
    cfg_write(D0, 4'b1100, 32'hFF03_0000);

    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = D1; cfg_be = 4'hf; cfg_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    for (int i = 0; i < 4; i++) ref_mem[12 + i] = 8'(32'h0BAD_0BAD >> (8 * i));
    cfg_addr = D0; cfg_be = 4'b0100; cfg_wdata = 32'h0011_0000;
    ap_req = 1'b1; ap_we = 1'b0; ap_addr = 8'd0; ap_size = 2'd0;
    #1 chk("R8 no ack busy", 32'(ap_ack), 32'd0);
    @(negedge clk);
    #1 chk("R8 no ack reload", 32'(ap_ack), 32'd0);
    cfg_wr = 1'b0;
    @(negedge clk);
    #1 chk("R8 ack after", 32'(ap_ack), 32'd1);
    @(negedge clk); ap_req = 1'b0;
    data_m = ref_word(12);
    cfg_read_chk("R7 dropped write", D0, {8'h0, 8'h03, 16'h0});
    cfg_read_chk("R4 reload sees write", D1, 32'h0BAD_0BAD);

    ap_access(1'b0, 0, 3, 0);
    ap_access(1'b0, 3, 1, 0);
    ap_access(1'b1, 158, 3, 32'h7788_99AA);
    ap_access(1'b0, 156, 3, 0);
    ap_access(1'b0, 158, 3, 0);
    ap_access(1'b0, 160, 0, 0);
    ap_access(1'b1, 255, 3, 32'h1234_5678);
    ap_access(1'b1, 21, 2, 32'h00FE_DCBA);
    ap_access(1'b0, 20, 3, 0);

    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 8);
      if (op < 6) begin
        ap_access(1'($urandom), int'($urandom % 256), int'($urandom % 4), $urandom);
      end else begin
        logic [5:0] a;
        logic [31:0] wd = $urandom;
        int k = int'($urandom % 5);
        a = (k < 2) ? D0 : (k < 4) ? D1 : 6'($urandom);
        wd[23:16] = 8'($urandom % 48);
        cfg_write(a, 4'($urandom), wd);
      end
    end
    finish_run();
  end
endmodule